// File: doc/BRIEF.md
# PCI Address Window Translator

This block sits between a processor's flat 32-bit local memory map and a PCI bus. The local side has only memory space, yet the bus has three address spaces: memory, I/O and configuration. Each of the three bus spaces is reached through its own window, and each window sits at a fixed place in the local map. A programmable base register per window picks which range of its bus space the window shows. A local request that lands in a window leaves as a bus address: the window's base register plus the request's offset inside the window. A two-bit space code goes with it.

For traffic coming in from the bus, three local resources can be offered as bus memory targets: external memory, the on-chip L2 memory and a block of control registers. Each resource has its own base register that places it in bus memory space, and its own enable bit. An inbound bus address that falls into an enabled aperture is claimed, and it is turned back into a local address. An address that matches no enabled aperture is a miss, and the bus-side target then leaves the transaction unclaimed.

Both paths are registered, so a result appears one clock after its request. Software programs the six base registers and the enable register through a simple write port.

Top module: `pci_window_xlate`

## Requirements
- R1: After synchronous reset, all six base registers read as zero and all aperture enables are clear. Both response valids are low, the space code is 11, and every address and hit output is zero.
- R2: A valid local request is decoded one clock later. The memory window sits at 0xE000_0000 and spans 2^24 bytes. The I/O window sits at 0xEE00_0000 and spans 2^16 bytes. The configuration window sits at 0xEF00_0000 and spans 2^16 bytes. A hit raises out_hit and gives out_space 00 for memory, 01 for I/O or 10 for configuration.
- R3: On a window hit, out_addr is the window's base register plus (local address minus window start), taken modulo 2^32.
- R4: A valid local request outside all three windows gives out_hit low, out_space 11 and out_addr zero.
- R5: Bits [1:0] of any base-register write are ignored and stored as zero. The register selects are: 0 memory window, 1 I/O window, 2 configuration window, 3 external-memory aperture, 4 L2 aperture, 5 control-register aperture.
- R6: A register write takes effect for requests presented from the following clock onward. A request in the same cycle as the write uses the old value.
- R7: An inbound address A is claimed when some aperture k is enabled and 0 <= A - base_k < 2^size_k. The size exponents are 26 for external memory, 18 for L2 and 12 for control registers. One clock later in_claim is high, in_hit has bit k set, and in_local_addr equals local_start_k + (A - base_k). The local starts are 0x0000_0000, 0xF000_0000 and 0xFFC0_0000.
- R8: An inbound address inside no enabled aperture, including one inside a disabled aperture, gives in_claim low, in_hit zero and in_local_addr zero.
- R9: When enabled apertures overlap, the lowest index wins: external memory, then L2, then control registers. in_hit never has more than one bit set.
- R10: out_valid and in_resp_valid repeat req_valid and in_valid one clock later. While a valid is low, its other outputs are held at their idle values (space 11, zeros).
- R11: The enable register is select 6, with bit 0 for external memory, bit 1 for L2 and bit 2 for control registers. A write to select 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local outbound request valid |
| req_addr | input | 32 | Local outbound request address |
| in_valid | input | 1 | Inbound bus address valid |
| in_addr | input | 32 | Inbound bus memory address |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0-5 bases, 6 enables, 7 unused) |
| reg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Outbound result valid |
| out_hit | output | 1 | Local address fell in a window |
| out_space | output | 2 | Bus space: 00 memory, 01 I/O, 10 configuration, 11 none |
| out_addr | output | 32 | Translated bus address |
| in_resp_valid | output | 1 | Inbound result valid |
| in_claim | output | 1 | Inbound address claimed |
| in_hit | output | 3 | One-hot aperture hit |
| in_local_addr | output | 32 | Local address of the claimed access |

## Verification
Every result of this block is due exactly one clock after its inputs are presented. This holds for the outbound space and address, and for the inbound claim, hit and local address. A register write, by contrast, changes results only for requests presented from the next clock onward. The bench drives each cycle's inputs at the falling edge and works out the expected outputs from its model state as it stood before that cycle's write. It applies the write to the model, waits through the rising edge and compares at the next falling edge. This way the same-cycle write case (R6) lands on the old value.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;

    localparam int ADDR_W  = 32;
    localparam int NUM_WIN = 3;
    localparam int NUM_AP  = 3;
    localparam int NUM_BASE = NUM_WIN + NUM_AP;
    localparam int RSEL_W  = 3;

    // Space code doubles as the window index: memory 0, I/O 1, config 2.
    typedef enum logic [1:0] {
        SP_MEM  = 2'b00,
        SP_IO   = 2'b01,
        SP_CFG  = 2'b10,
        SP_NONE = 2'b11
    } pci_space_e;

    typedef enum logic [RSEL_W-1:0] {
        RS_WIN_MEM  = 3'd0,
        RS_WIN_IO   = 3'd1,
        RS_WIN_CFG  = 3'd2,
        RS_AP_EXT   = 3'd3,
        RS_AP_L2    = 3'd4,
        RS_AP_CTL   = 3'd5,
        RS_ENABLE   = 3'd6,
        RS_SPARE    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              hit;
        pci_space_e        space;
        logic [ADDR_W-1:0] addr;
    } out_xact_t;

    typedef struct packed {
        logic              valid;
        logic              claim;
        logic [NUM_AP-1:0] hit;
        logic [ADDR_W-1:0] laddr;
    } in_xact_t;

    localparam out_xact_t OUT_IDLE = '{valid: 1'b0, hit: 1'b0, space: SP_NONE, addr: '0};
    localparam in_xact_t  IN_IDLE  = '{valid: 1'b0, claim: 1'b0, hit: '0, laddr: '0};

    function automatic logic [ADDR_W-1:0] align_dword(input logic [ADDR_W-1:0] v);
        return {v[ADDR_W-1:2], 2'b00};
    endfunction

    function automatic logic same_window(input logic [ADDR_W-1:0] a,
                                         input logic [ADDR_W-1:0] start,
                                         input int               span_w);
        return (a >> span_w) == (start >> span_w);
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(input int span_w);
        return (ADDR_W'(1) << span_w) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
    import pciwin_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_we,
    input  logic [RSEL_W-1:0]       reg_sel,
    input  logic [ADDR_W-1:0]       reg_wdata,
    output logic [ADDR_W-1:0]       win_base [NUM_WIN],
    output logic [ADDR_W-1:0]       ap_base  [NUM_AP],
    output logic [NUM_AP-1:0]       ap_en
);

    logic [ADDR_W-1:0] base_q [NUM_BASE];
    logic [NUM_AP-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BASE; i++) base_q[i] <= '0;
            en_q <= '0;
        end else if (reg_we) begin
            for (int i = 0; i < NUM_BASE; i++) begin
                if (reg_sel == RSEL_W'(i)) base_q[i] <= align_dword(reg_wdata);
            end
            if (reg_sel == RS_ENABLE) en_q <= reg_wdata[NUM_AP-1:0];
        end
    end

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_out
            assign win_base[w] = base_q[w];
        end
        for (genvar k = 0; k < NUM_AP; k++) begin : g_ap_out
            assign ap_base[k] = base_q[NUM_WIN + k];
        end
    endgenerate
    assign ap_en = en_q;

    generate
        for (genvar i = 0; i < NUM_BASE; i++) begin : g_chk
            // R5: a base write keeps the upper bits and clears the low two
            p_base_load_r5: assert property (@(posedge clk) disable iff (rst)
                (reg_we && reg_sel == RSEL_W'(i))
                |=> (base_q[i] == {$past(reg_wdata[ADDR_W-1:2]), 2'b00}));
            // R11: the spare select leaves every base untouched
            p_spare_base_r11: assert property (@(posedge clk) disable iff (rst)
                (reg_we && reg_sel == RS_SPARE) |=> $stable(base_q[i]));
        end
    endgenerate

    // R11: the spare select leaves the enables untouched
    p_spare_en_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == RS_SPARE) |=> $stable(en_q));

endmodule

// File: rtl/pciwin_out_xlate.sv
module pciwin_out_xlate
    import pciwin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MEM_LBASE = 32'hE000_0000,
    parameter int                MEM_OFF_W = 24,
    parameter logic [ADDR_W-1:0] IO_LBASE  = 32'hEE00_0000,
    parameter int                IO_OFF_W  = 16,
    parameter logic [ADDR_W-1:0] CFG_LBASE = 32'hEF00_0000,
    parameter int                CFG_OFF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] win_base [NUM_WIN],
    output logic              out_valid,
    output logic              out_hit,
    output pci_space_e        out_space,
    output logic [ADDR_W-1:0] out_addr
);

    localparam logic [ADDR_W-1:0] LSTART [NUM_WIN] = '{MEM_LBASE, IO_LBASE, CFG_LBASE};
    localparam int                OFFW   [NUM_WIN] = '{MEM_OFF_W, IO_OFF_W, CFG_OFF_W};

    logic [NUM_WIN-1:0] win_hit;
    logic [ADDR_W-1:0]  win_xl [NUM_WIN];
    out_xact_t          nxt, cur_q;

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            localparam logic [ADDR_W-1:0] MASK = low_mask(OFFW[w]);
            assign win_hit[w] = same_window(req_addr, LSTART[w], OFFW[w]);
            assign win_xl[w]  = win_base[w] + (req_addr & MASK);
        end
    endgenerate

    always_comb begin
        nxt = OUT_IDLE;
        if (req_valid) begin
            nxt.valid = 1'b1;
            for (int w = NUM_WIN - 1; w >= 0; w--) begin
                if (win_hit[w]) begin
                    nxt.hit   = 1'b1;
                    nxt.space = pci_space_e'(w[1:0]);
                    nxt.addr  = win_xl[w];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= OUT_IDLE;
        else     cur_q <= nxt;
    end

    assign out_valid = cur_q.valid;
    assign out_hit   = cur_q.hit;
    assign out_space = cur_q.space;
    assign out_addr  = cur_q.addr;

    // R10: a request always yields a result on the next clock
    p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    // R10: no request means idle outputs next clock
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && out_space == SP_NONE && out_addr == '0));
    // R2: a hit always names a real space
    p_hit_space_r2: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (out_valid && out_space != SP_NONE));
    // R4: a miss carries the none code and a zero address
    p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_hit) |-> (out_space == SP_NONE && out_addr == '0));

endmodule

// File: rtl/pciwin_in_match.sv
module pciwin_in_match
    import pciwin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EXT_LBASE  = 32'h0000_0000,
    parameter int                EXT_SIZE_W = 26,
    parameter logic [ADDR_W-1:0] L2_LBASE   = 32'hF000_0000,
    parameter int                L2_SIZE_W  = 18,
    parameter logic [ADDR_W-1:0] CTL_LBASE  = 32'hFFC0_0000,
    parameter int                CTL_SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [ADDR_W-1:0] ap_base [NUM_AP],
    input  logic [NUM_AP-1:0] ap_en,
    output logic              in_resp_valid,
    output logic              in_claim,
    output logic [NUM_AP-1:0] in_hit,
    output logic [ADDR_W-1:0] in_local_addr
);

    localparam logic [ADDR_W-1:0] LSTART [NUM_AP] = '{EXT_LBASE, L2_LBASE, CTL_LBASE};
    localparam int                SIZEW  [NUM_AP] = '{EXT_SIZE_W, L2_SIZE_W, CTL_SIZE_W};

    logic [NUM_AP-1:0] ap_match;
    logic [ADDR_W-1:0] ap_off   [NUM_AP];
    logic [ADDR_W-1:0] ap_local [NUM_AP];
    in_xact_t          nxt, cur_q;

    generate
        for (genvar k = 0; k < NUM_AP; k++) begin : g_ap
            // Distance from the aperture base; a wrap makes it huge, so one compare covers both ends.
            assign ap_off[k]   = in_addr - ap_base[k];
            assign ap_match[k] = ap_en[k] && ((ap_off[k] >> SIZEW[k]) == '0);
            assign ap_local[k] = LSTART[k] + ap_off[k];
        end
    endgenerate

    always_comb begin
        nxt = IN_IDLE;
        if (in_valid) begin
            nxt.valid = 1'b1;
            for (int k = NUM_AP - 1; k >= 0; k--) begin
                if (ap_match[k]) begin
                    nxt.claim = 1'b1;
                    nxt.hit   = NUM_AP'(1) << k;
                    nxt.laddr = ap_local[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= IN_IDLE;
        else     cur_q <= nxt;
    end

    assign in_resp_valid = cur_q.valid;
    assign in_claim      = cur_q.claim;
    assign in_hit        = cur_q.hit;
    assign in_local_addr = cur_q.laddr;

    // R9: at most one aperture is reported
    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_hit));
    // R7: a claim only accompanies a valid result with a hit bit
    p_claim_valid_r7: assert property (@(posedge clk) disable iff (rst)
        in_claim |-> (in_resp_valid && in_hit != '0));
    // R8: unclaimed results carry no address
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !in_claim |-> (in_hit == '0 && in_local_addr == '0));
    // R10: inbound valid follows its request by one clock
    p_in_follow_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> in_resp_valid);

    generate
        for (genvar k = 0; k < NUM_AP; k++) begin : g_chk
            // R8: a disabled aperture is never reported
            p_enabled_r8: assert property (@(posedge clk) disable iff (rst)
                in_hit[k] |-> $past(ap_en[k]));
        end
    endgenerate

endmodule

// File: rtl/pci_window_xlate.sv
module pci_window_xlate
    import pciwin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MEM_WIN_LBASE = 32'hE000_0000,
    parameter int                MEM_WIN_OFF_W = 24,
    parameter logic [ADDR_W-1:0] IO_WIN_LBASE  = 32'hEE00_0000,
    parameter int                IO_WIN_OFF_W  = 16,
    parameter logic [ADDR_W-1:0] CFG_WIN_LBASE = 32'hEF00_0000,
    parameter int                CFG_WIN_OFF_W = 16,
    parameter logic [ADDR_W-1:0] EXT_AP_LBASE  = 32'h0000_0000,
    parameter int                EXT_AP_SIZE_W = 26,
    parameter logic [ADDR_W-1:0] L2_AP_LBASE   = 32'hF000_0000,
    parameter int                L2_AP_SIZE_W  = 18,
    parameter logic [ADDR_W-1:0] CTL_AP_LBASE  = 32'hFFC0_0000,
    parameter int                CTL_AP_SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              in_valid,
    input  logic [31:0]       in_addr,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic              out_valid,
    output logic              out_hit,
    output logic [1:0]        out_space,
    output logic [31:0]       out_addr,
    output logic              in_resp_valid,
    output logic              in_claim,
    output logic [2:0]        in_hit,
    output logic [31:0]       in_local_addr
);

    logic [ADDR_W-1:0] win_base [NUM_WIN];
    logic [ADDR_W-1:0] ap_base  [NUM_AP];
    logic [NUM_AP-1:0] ap_en;
    pci_space_e        space_w;

    pciwin_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .win_base  (win_base),
        .ap_base   (ap_base),
        .ap_en     (ap_en)
    );

    pciwin_out_xlate #(
        .MEM_LBASE (MEM_WIN_LBASE),
        .MEM_OFF_W (MEM_WIN_OFF_W),
        .IO_LBASE  (IO_WIN_LBASE),
        .IO_OFF_W  (IO_WIN_OFF_W),
        .CFG_LBASE (CFG_WIN_LBASE),
        .CFG_OFF_W (CFG_WIN_OFF_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .win_base  (win_base),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_space (space_w),
        .out_addr  (out_addr)
    );

    assign out_space = space_w;

    pciwin_in_match #(
        .EXT_LBASE  (EXT_AP_LBASE),
        .EXT_SIZE_W (EXT_AP_SIZE_W),
        .L2_LBASE   (L2_AP_LBASE),
        .L2_SIZE_W  (L2_AP_SIZE_W),
        .CTL_LBASE  (CTL_AP_LBASE),
        .CTL_SIZE_W (CTL_AP_SIZE_W)
    ) u_in (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_addr       (in_addr),
        .ap_base       (ap_base),
        .ap_en         (ap_en),
        .in_resp_valid (in_resp_valid),
        .in_claim      (in_claim),
        .in_hit        (in_hit),
        .in_local_addr (in_local_addr)
    );

endmodule

// File: tb/pci_window_xlate_tb_top.sv
`timescale 1ns/1ps
module pci_window_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, in_valid, reg_we;
    logic [31:0] req_addr, in_addr, reg_wdata;
    logic [2:0]  reg_sel;
    logic        out_valid, out_hit, in_resp_valid, in_claim;
    logic [1:0]  out_space;
    logic [31:0] out_addr, in_local_addr;
    logic [2:0]  in_hit;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Behavioural model state
    logic [31:0] m_base [6];
    logic [2:0]  m_en;
    int          woff [3] = '{24, 16, 16};
    logic [31:0] wlb  [3] = '{32'hE000_0000, 32'hEE00_0000, 32'hEF00_0000};
    int          apw  [3] = '{26, 18, 12};
    logic [31:0] alb  [3] = '{32'h0000_0000, 32'hF000_0000, 32'hFFC0_0000};

    always #2.5 clk = ~clk;

    pci_window_xlate dut_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .in_valid      (in_valid),
        .in_addr       (in_addr),
        .reg_we        (reg_we),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .out_valid     (out_valid),
        .out_hit       (out_hit),
        .out_space     (out_space),
        .out_addr      (out_addr),
        .in_resp_valid (in_resp_valid),
        .in_claim      (in_claim),
        .in_hit        (in_hit),
        .in_local_addr (in_local_addr)
    );

    task automatic model_out(input bit v, input logic [31:0] a, output logic [35:0] e);
        e = {1'b0, 1'b0, 2'b11, 32'h0};
        if (v) begin
            e[35] = 1'b1;
            for (int w = 0; w < 3; w++) begin
                if ((a >> woff[w]) == (wlb[w] >> woff[w]))
                    e = {1'b1, 1'b1, 2'(w), m_base[w] + (a - wlb[w])};
            end
        end
    endtask

    task automatic model_in(input bit v, input logic [31:0] a, output logic [36:0] e);
        bit found = 1'b0;
        e = {1'b0, 1'b0, 3'b000, 32'h0};
        if (v) begin
            e[36] = 1'b1;
            for (int k = 0; k < 3; k++) begin
                logic [31:0] off;
                off = a - m_base[3 + k];
                if (!found && m_en[k] && (longint'(off) < (longint'(1) << apw[k]))) begin
                    found = 1'b1;
                    e = {1'b1, 1'b1, 3'(1 << k), alb[k] + off};
                end
            end
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare at the next falling edge.
    task automatic cyc(input string tag,
                       input bit rv, input logic [31:0] ra,
                       input bit iv, input logic [31:0] ia,
                       input bit we, input logic [2:0] sel, input logic [31:0] wd);
        logic [35:0] eo;
        logic [36:0] ei;
        req_valid = rv; req_addr = ra;
        in_valid  = iv; in_addr  = ia;
        reg_we    = we; reg_sel  = sel; reg_wdata = wd;
        model_out(rv, ra, eo);
        model_in(iv, ia, ei);
        if (we) begin
            if (sel < 3'd6)       m_base[sel] = {wd[31:2], 2'b00};
            else if (sel == 3'd6) m_en = wd[2:0];
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "outbound", 64'({out_valid, out_hit, out_space, out_addr}), 64'(eo));
        check(tag, "inbound",  64'({in_resp_valid, in_claim, in_hit, in_local_addr}), 64'(ei));
    endtask

    task automatic wr(input string tag, input logic [2:0] sel, input logic [31:0] wd);
        cyc(tag, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, sel, wd);
    endtask

    task automatic req(input string tag, input logic [31:0] ra);
        cyc(tag, 1'b1, ra, 1'b0, 32'h0, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic inb(input string tag, input logic [31:0] ia);
        cyc(tag, 1'b0, 32'h0, 1'b1, ia, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) m_base[i] = '0;
        m_en = '0;
        rst = 1'b1;
        req_valid = 0; req_addr = 0; in_valid = 0; in_addr = 0;
        reg_we = 0; reg_sel = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values at the ports
        check("R1", "reset outbound", 64'({out_valid, out_hit, out_space, out_addr}),
              64'({1'b0, 1'b0, 2'b11, 32'h0}));
        check("R1", "reset inbound", 64'({in_resp_valid, in_claim, in_hit, in_local_addr}),
              64'({1'b0, 1'b0, 3'b000, 32'h0}));
        // R1: bases are zero and enables clear
        cyc("R1", 1'b1, 32'hE000_1234, 1'b1, 32'h0000_0100, 1'b0, 3'd0, 32'h0);

        // R5: low two bits dropped
        wr("R5", 3'd0, 32'h8000_0003);
        req("R5", 32'hE012_3454);
        // R6: same-cycle write uses the old I/O base, then the new one
        cyc("R6", 1'b1, 32'hEE00_0123, 1'b0, 32'h0, 1'b1, 3'd1, 32'h0000_C002);
        req("R6", 32'hEE00_0123);
        // R2 / R3: each space
        wr("R3", 3'd2, 32'h0001_0800);
        req("R2", 32'hEF00_0FFC);
        req("R2", 32'hE0FF_FFFF);
        req("R3", 32'hEE00_FFFF);
        // R3: modulo wrap
        wr("R3", 3'd0, 32'hFFFF_FF00);
        req("R3", 32'hE000_0200);
        // R4: misses just outside each window
        req("R4", 32'hE100_0000);
        req("R4", 32'hEE01_0000);
        req("R4", 32'hDFFF_FFFF);
        req("R4", 32'hEF01_0000);
        // R10: idle request with in-window address
        cyc("R10", 1'b0, 32'hE000_0040, 1'b0, 32'h4000_0000, 1'b0, 3'd0, 32'h0);

        // Apertures
        wr("R7", 3'd3, 32'h4000_0000);
        wr("R7", 3'd4, 32'h5000_0000);
        wr("R7", 3'd5, 32'h6000_0001);
        wr("R11", 3'd6, 32'h0000_0005);
        inb("R7", 32'h4000_0010);
        inb("R7", 32'h43FF_FFFC);
        inb("R8", 32'h4400_0000);
        inb("R8", 32'h3FFF_FFFC);
        inb("R8", 32'h5000_0000);
        inb("R7", 32'h6000_0FFC);
        inb("R8", 32'h6000_1000);
        wr("R11", 3'd6, 32'h0000_0007);
        inb("R7", 32'h5003_FFFC);
        inb("R8", 32'h5004_0000);
        // R9: overlap, lowest index wins
        wr("R9", 3'd4, 32'h4000_0000);
        inb("R9", 32'h4000_0020);
        wr("R9", 3'd6, 32'h0000_0006);
        inb("R9", 32'h4000_0020);
        // R11: spare select changes nothing
        wr("R11", 3'd7, 32'hFFFF_FFFF);
        cyc("R11", 1'b1, 32'hEE00_0010, 1'b1, 32'h4000_0020, 1'b0, 3'd0, 32'h0);
        cyc("R11", 1'b1, 32'hE000_0010, 1'b1, 32'h0000_0000, 1'b0, 3'd0, 32'h0);
        // R10: both sides together with a concurrent write
        cyc("R10", 1'b1, 32'hEF00_0100, 1'b1, 32'h6000_0004, 1'b1, 3'd2, 32'h1234_5678);
        cyc("R10", 1'b1, 32'hEF00_0100, 1'b0, 32'h6000_0004, 1'b0, 3'd0, 32'h0);

        // R2: sweep across the upper map
        for (int k = 0; k < 64; k++) begin
            logic [31:0] a;
            a = 32'hDF80_0000 + 32'(k) * 32'h0044_4444;
            cyc("R2", 1'b1, a, 1'b1, a ^ 32'h9E00_0000, 1'b0, 3'd0, 32'h0);
        end

        finish_run();
    end

endmodule